// File: doc/BRIEF.md
# SONET/SDH Byte Aligner with Severely Errored Frame Detection

The block sits behind a 1:8 deserialiser that has no notion of byte boundaries. It receives one byte per clock and looks for the A1/A2 framing word at every one of the eight possible bit offsets. When it finds the word, it fixes both the bit offset and the position inside the frame. From then on it delivers re-aligned bytes together with a byte index and a pulse that marks the first byte of each frame.

Once per frame, the block checks the framing word again at the locked alignment. A mismatch raises a framing-error pulse. A run of errored frames raises the Severely Errored Frame (SEF) flag, and consecutive clean frames clear it.

Acquisition is controlled by a level-sensitive input, which is normally tied to the SEF output. While SEF is low, a false pattern inside the payload cannot move the alignment. While SEF is high, the block re-hunts on every cycle. A loss-of-signal input zeroes the data path and forces SEF immediately.

Top module: `sonet_frame_aligner`

## Requirements
- R1: While `rst_n` is low and directly after it rises, `sef` is 1, `frm_err` is 0 and `frame_start` is 0.
- R2: The framing word is 3N bytes of 0xF6 followed by 3N bytes of 0x28, received MSB first. At any of the eight bit offsets, a match while hunting locks that offset (the lowest offset wins if several match). `al_byte` then carries the original bytes, so a byte fed on clock t appears on `al_byte` after edge t+2.
- R3: `rate_sel` selects N: 01 gives 3, 10 gives 12, 00 gives 48. The frame is ROWS*STS_COLS*N bytes long. After lock, `byte_pos` gives the frame index (from 0) of the byte on `al_byte`, and `frame_start` is 1 exactly together with index 0.
- R4: Once per frame, the block checks the window ending at index 3N+2 at the locked offset. Any bit mismatch inside the selected window drives `frm_err` high for exactly ERR_PULSE (16) clocks.
- R5: `sef` rises at the check of the fourth consecutive errored frame. A clean frame restarts the count.
- R6: `sef` falls at the second consecutive clean framing check. A match found while hunting counts as a clean check.
- R7: `hunt_en` is level sensitive. While it is low, a bit slip never changes the alignment. While it is high, the block relocks on the next framing word at the new offset.
- R8: `pat_sel` selects the compared window, counted over the last three A1 bytes and the first three A2 bytes. 01 compares all 48 bits. 10 compares the 24 bits nearest the A1/A2 boundary. 00 compares the 12 bits nearest it. 11 turns off both hunting and checking, so `frm_err` stays low and `sef` holds its value.
- R9: While `los` is 1, the incoming data is treated as zero (`al_byte` becomes 0) and `sef` is 1 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Unaligned byte from the deserialiser, earliest bit in bit 7 |
| los | input | 1 | Loss of signal |
| hunt_en | input | 1 | Level-sensitive acquisition enable |
| pat_sel | input | 2 | Framing window width select |
| rate_sel | input | 2 | Line rate select |
| al_byte | output | 8 | Re-aligned byte |
| frame_start | output | 1 | High with byte 0 of each frame |
| byte_pos | output | PW | Frame index of `al_byte` |
| frm_err | output | 1 | Framing-error pulse |
| sef | output | 1 | Severely Errored Frame flag |

## Verification
The bench builds the block with ROWS=3 and STS_COLS=10, which gives frames of 90, 360 and 1440 bytes. With these sizes, runs of a dozen frames, bit slips, window-width changes, loss of signal and all three rates fit within a short run. ERR_PULSE stays at 16 and the SEF run lengths stay at 4 and 2. As a result, the pulse length and the entry and exit counts checked are the full-size values, and only the frame length is shrunk.

// File: rtl/sonet_frame_aligner.sv
module sonet_frame_aligner #(
  parameter int ROWS      = 9,
  parameter int STS_COLS  = 90,
  parameter int ERR_PULSE = 16,
  parameter int SEF_BAD   = 4,
  parameter int SEF_GOOD  = 2,
  localparam int PW = $clog2(ROWS * STS_COLS * 48)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rx_byte,
  input  logic          los,
  input  logic          hunt_en,
  input  logic [1:0]    pat_sel,
  input  logic [1:0]    rate_sel,
  output logic [7:0]    al_byte,
  output logic          frame_start,
  output logic [PW-1:0] byte_pos,
  output logic          frm_err,
  output logic          sef
);

  localparam int EW = $clog2(ERR_PULSE + 1);
  localparam int BW = $clog2(SEF_BAD + 1);
  localparam int GW = $clog2(SEF_GOOD + 1);
  localparam logic [47:0] PATTERN = 48'hF6F6F6_282828;

  logic [55:0]   hist;
  logic [2:0]    offs;
  logic          locked;
  logic [PW-1:0] pos;
  logic [EW-1:0] pulse_cnt;
  logic [BW-1:0] bad_run;
  logic [GW-1:0] good_run;

  logic [PW-1:0] nsts, flen, wend, pos_cur, pos_nxt;
  logic [47:0]   mask;
  logic [47:0]   win [8];
  logic [7:0]    hit;
  logic [2:0]    hit_idx;
  logic          any_hit, detect_on, relock, at_check, ev_good, ev_bad;

  always_comb begin
    case (rate_sel)
      2'b10:   nsts = PW'(12);
      2'b00:   nsts = PW'(48);
      default: nsts = PW'(3);
    endcase
    case (pat_sel)
      2'b01:   mask = 48'hFFFFFF_FFFFFF;
      2'b10:   mask = 48'h000FFF_FFF000;
      2'b00:   mask = 48'h00003F_FC0000;
      default: mask = '0;
    endcase
  end

  assign flen      = PW'(ROWS * STS_COLS) * nsts;
  assign wend      = PW'(3) * nsts + PW'(2);
  assign detect_on = (pat_sel != 2'b11);

  for (genvar k = 0; k < 8; k++) begin : g_off
    assign win[k] = hist[55-k -: 48];
    assign hit[k] = ((win[k] ^ PATTERN) & mask) == '0;
  end

  always_comb begin
    hit_idx = '0;
    any_hit = 1'b0;
    for (int k = 7; k >= 0; k--) begin
      if (hit[k]) begin
        hit_idx = 3'(k);
        any_hit = 1'b1;
      end
    end
  end

  assign relock   = hunt_en && detect_on && any_hit;
  assign at_check = locked && detect_on && (pos == wend);
  assign ev_good  = relock || (at_check && hit[offs]);
  assign ev_bad   = !relock && at_check && !hit[offs];
  assign pos_cur  = relock ? wend : pos;
  assign pos_nxt  = (pos_cur >= flen - PW'(1)) ? '0 : pos_cur + PW'(1);
  assign frm_err  = (pulse_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist        <= '0;
      offs        <= '0;
      locked      <= 1'b0;
      pos         <= '0;
      al_byte     <= '0;
      byte_pos    <= '0;
      frame_start <= 1'b0;
    end else begin
      hist        <= {hist[47:0], los ? 8'h00 : rx_byte};
      if (relock) offs <= hit_idx;
      locked      <= locked || relock;
      pos         <= pos_nxt;
      al_byte     <= relock ? win[hit_idx][7:0] : win[offs][7:0];
      byte_pos    <= pos_cur;
      frame_start <= (locked || relock) && (pos_cur == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pulse_cnt <= '0;
    else if (ev_bad)
      pulse_cnt <= EW'(ERR_PULSE);
    else if (pulse_cnt != '0)
      pulse_cnt <= pulse_cnt - EW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sef      <= 1'b1;
      bad_run  <= '0;
      good_run <= '0;
    end else if (los) begin
      sef      <= 1'b1;
      bad_run  <= BW'(SEF_BAD);
      good_run <= '0;
    end else if (ev_bad) begin
      good_run <= '0;
      if (bad_run < BW'(SEF_BAD)) bad_run <= bad_run + BW'(1);
      if (bad_run >= BW'(SEF_BAD - 1)) sef <= 1'b1;
    end else if (ev_good) begin
      bad_run <= '0;
      if (good_run < GW'(SEF_GOOD)) good_run <= good_run + GW'(1);
      if (good_run >= GW'(SEF_GOOD - 1)) sef <= 1'b0;
    end
  end

endmodule

// File: rtl/sonet_frame_aligner_chk.sv
module sonet_frame_aligner_chk #(
  parameter int ERR_PULSE = 16,
  parameter int PW        = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          los,
  input logic [1:0]    pat_sel,
  input logic          frame_start,
  input logic [PW-1:0] byte_pos,
  input logic          frm_err,
  input logic          sef
);

  localparam int HW = $clog2(ERR_PULSE + 2);
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hi_run <= '0;
    else if (!frm_err)
      hi_run <= '0;
    else if (hi_run <= HW'(ERR_PULSE))
      hi_run <= hi_run + HW'(1);
  end

  AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) hi_run <= HW'(ERR_PULSE)); // R4
  AST_LOS_FORCES_SEF: assert property (@(posedge clk) disable iff (!rst_n) los |=> sef); // R9
  AST_SOF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) frame_start |-> byte_pos == '0); // R3
  AST_SEF_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sef) |-> (frm_err || $past(los))); // R5
  AST_SEF_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(sef) |-> !$past(los)); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(frm_err) |-> $past(pat_sel) != 2'b11); // R8

endmodule

bind sonet_frame_aligner sonet_frame_aligner_chk #(.ERR_PULSE(ERR_PULSE), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .los(los), .pat_sel(pat_sel), .frame_start(frame_start),
  .byte_pos(byte_pos), .frm_err(frm_err), .sef(sef)
);

// File: tb/sonet_frame_aligner_bench.sv
module sonet_frame_aligner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 3;
  localparam int COLS = 10;
  localparam int PW = $clog2(ROWS * COLS * 48);

  // table entry: {corrupt[1:0], expected sef after frame, expected frm_err pulse}
  localparam logic [3:0] TBL [11] = '{
    4'b0010, 4'b0000, 4'b0101, 4'b0101, 4'b0000, 4'b0101,
    4'b0101, 4'b0101, 4'b0111, 4'b0010, 4'b0000
  };

  logic clk = 1'b0, rst_n = 1'b0, los = 1'b0, tie = 1'b1, en_force = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [1:0] pat_sel = 2'b10, rate_sel = 2'b01;
  logic [7:0] al_byte;
  logic frame_start, frm_err, sef, hunt_en;
  logic [PW-1:0] byte_pos;

  int checks = 0, errors = 0;
  int offk = 3;
  logic [7:0] prev_lb = 8'h00;
  int fr_hi, sof_j, end_sef;
  bit mark_ok, done = 0;

  assign hunt_en = tie ? sef : en_force;
  always #(CLK_PERIOD/2) clk = ~clk;

  sonet_frame_aligner #(.ROWS(ROWS), .STS_COLS(COLS)) u_sonet_frame_aligner (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .los(los), .hunt_en(hunt_en),
    .pat_sel(pat_sel), .rate_sel(rate_sel), .al_byte(al_byte), .frame_start(frame_start),
    .byte_pos(byte_pos), .frm_err(frm_err), .sef(sef)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lbyte(input int j, input int n, input int corrupt);
    logic [7:0] b;
    if (j < 3*n) b = 8'hF6;
    else if (j < 6*n) b = 8'h28;
    else if (j == ROWS*COLS*n/2) b = 8'hA5;
    else b = 8'h00;
    if (corrupt == 1 && j == 3*n-1) b ^= 8'h01;
    if (corrupt == 2 && j == 3*n-3) b ^= 8'h80;
    if (corrupt == 3 && j == 3*n-2) b ^= 8'h01;
    return b;
  endfunction

  task automatic send_frame(input int n, input int corrupt);
    int fl = ROWS*COLS*n;
    logic [15:0] pair;
    logic [7:0] lb;
    fr_hi = 0; sof_j = -1; mark_ok = 0; end_sef = 0;
    for (int j = 0; j < fl; j++) begin
      @(negedge clk);
      if (frm_err) fr_hi++;
      if (frame_start && sof_j < 0) sof_j = j;
      if (j == fl/2 + 3) mark_ok = (al_byte == 8'hA5) && (byte_pos == PW'(fl/2));
      if (j == fl-1) end_sef = int'(sef);
      lb = lbyte(j, n, corrupt);
      pair = {prev_lb, lb} >> offk;
      rx_byte = pair[7:0];
      prev_lb = lb;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_byte = 8'h00; prev_lb = 8'h00;
    repeat (3) @(negedge clk);
    chk(sef == 1'b1 && frm_err == 1'b0 && frame_start == 1'b0, "R1 reset outputs", int'(sef), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sef == 1'b1 && frm_err == 1'b0 && frame_start == 1'b0, "R1 after reset", int'(sef), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();

    // table walk: 24-bit window, STS-3, offset 3
    for (int i = 0; i < 11; i++) begin
      send_frame(3, int'(TBL[i][3:2]));
      chk(end_sef == int'(TBL[i][1]), "R5 R6 sef after frame", end_sef, int'(TBL[i][1]));
      chk(fr_hi == (TBL[i][0] ? 16 : 0), "R4 frm_err pulse length", fr_hi, TBL[i][0] ? 16 : 0);
      chk(mark_ok, "R2 aligned marker byte", int'(mark_ok), 1);
      if (i > 0) chk(sof_j == 3, "R3 frame_start at byte 0", sof_j, 3);
    end

    // window widths
    pat_sel = 2'b00; send_frame(3, 3);
    chk(fr_hi == 0, "R8 12-bit ignores outer bits", fr_hi, 0);
    send_frame(3, 1);
    chk(fr_hi == 16, "R8 12-bit sees boundary bit", fr_hi, 16);
    pat_sel = 2'b10; send_frame(3, 2);
    chk(fr_hi == 0, "R8 24-bit ignores first window byte", fr_hi, 0);
    send_frame(3, 3);
    chk(fr_hi == 16, "R8 24-bit sees inner bit", fr_hi, 16);
    pat_sel = 2'b01; send_frame(3, 2);
    chk(fr_hi == 16, "R8 48-bit sees first window byte", fr_hi, 16);
    send_frame(3, 0);
    chk(end_sef == 0, "R5 three errored frames keep sef low", end_sef, 0);

    // detection off
    pat_sel = 2'b11;
    for (int i = 0; i < 5; i++) begin
      send_frame(3, 1);
      chk(fr_hi == 0 && end_sef == 0, "R8 disabled: no error, sef held", fr_hi, 0);
    end
    pat_sel = 2'b10;
    send_frame(3, 0);

    // bit slip with enable low, then hunting
    offk = 6;
    for (int i = 0; i < 4; i++) begin
      send_frame(3, 0);
      chk(end_sef == (i == 3 ? 1 : 0), "R5 slip errored run", end_sef, i == 3 ? 1 : 0);
      chk(fr_hi == 16, "R4 slip error pulse", fr_hi, 16);
      if (i == 0) chk(!mark_ok, "R7 no relock with enable low", int'(mark_ok), 0);
    end
    send_frame(3, 0);
    chk(end_sef == 1 && mark_ok, "R7 relock at new offset", end_sef, 1);
    send_frame(3, 0);
    chk(end_sef == 0 && mark_ok, "R6 sef clears after two clean", end_sef, 0);

    // enable forced high while in frame: relock stays put on clean stream
    tie = 1'b0; en_force = 1'b1;
    send_frame(3, 0);
    chk(end_sef == 0 && mark_ok && sof_j == 3, "R7 hunting on clean stream", end_sef, 0);
    tie = 1'b1;

    // loss of signal
    @(negedge clk); los = 1'b1; rx_byte = 8'hFF;
    @(negedge clk);
    chk(sef == 1'b1, "R9 sef one edge after los", int'(sef), 1);
    repeat (3) @(negedge clk);
    chk(al_byte == 8'h00, "R9 data forced to zero", int'(al_byte), 0);
    los = 1'b0; prev_lb = 8'h00;
    send_frame(3, 0);
    chk(end_sef == 1, "R9 sef still high after first relock", end_sef, 1);
    send_frame(3, 0);
    chk(end_sef == 0 && mark_ok, "R6 recovery after los", end_sef, 0);

    // STS-12, offset 0
    rate_sel = 2'b10; offk = 0;
    do_reset();
    send_frame(12, 0);
    chk(end_sef == 1, "R3 STS-12 first frame", end_sef, 1);
    send_frame(12, 0);
    chk(end_sef == 0 && mark_ok && sof_j == 3, "R3 STS-12 framing", end_sef, 0);

    // STS-48, offset 7
    rate_sel = 2'b00; offk = 7;
    do_reset();
    send_frame(48, 0);
    send_frame(48, 0);
    chk(end_sef == 0 && mark_ok && sof_j == 3, "R3 R2 STS-48 offset 7", end_sef, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule